// File: doc/BRIEF.md
# Dual Page-Size Translation Buffer

This block caches virtual-to-real address translations for two page sizes at once: 4 KB small pages and 1 MB large pages. Each size has its own two-way set-associative array, and a lookup probes both arrays in the same cycle. One large entry covers the address span that would otherwise take 256 small entries. This keeps the number of entries needed for big, long-lived mappings low.

A requester presents a virtual address on the lookup port. One clock later the block returns a hit flag, the real address and a flag that says which page size matched. On a miss the requester hands the address to a separate table walker. The walker's result comes back through the fill port, tagged with its page size, and is installed in the matching array. A purge input invalidates every entry in both arrays in a single cycle.

Top module: `dpst_tlb`

## Requirements
- R1: After reset every entry is invalid, `rspValid` and `rspHit` are low, and any lookup misses until a fill has been made.
- R2: A lookup presented in cycle t is answered in cycle t+1 with `rspValid` high. `rspValid` is low in every cycle that does not follow a lookup.
- R3: Small array: 256 sets, 2 ways, set index from virtual address bits [19:12], tag from bits [31:20]. On a small hit, `rspPaddr` is the stored 20-bit frame number followed by virtual address bits [11:0], and `rspLarge` is 0.
- R4: Large array: 32 sets, 2 ways, set index from bits [24:20], tag from bits [31:25]. On a large hit, `rspPaddr` is the stored 12-bit frame number followed by virtual address bits [19:0], and `rspLarge` is 1. Any address inside the 1 MB page hits.
- R5: When both arrays hit, the large entry supplies the result.
- R6: On a miss, `rspHit`, `rspLarge` and `rspPaddr` are all zero.
- R7: A fill goes into an invalid way of its set before any valid way is evicted. Way 0 is used before way 1.
- R8: When both ways of a set are valid, a fill evicts the way that was not used most recently. Both a lookup hit and a fill count as a use. If a fill and a hit touch the same set in one cycle, the victim is chosen from the state before that cycle, and the fill counts as the later use.
- R9: A fill whose tag already sits valid in its set overwrites that way in place. The other way of the set is kept.
- R10: `purgeAll` invalidates both arrays in one cycle. A lookup in that same cycle reports a miss. A fill in that same cycle is dropped.
- R11: A lookup in the same cycle as a fill sees the contents from before the fill. The new entry is visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 32 | Lookup virtual address |
| fillValid | input | 1 | Install an entry |
| fillLarge | input | 1 | 1: entry is a 1 MB page, 0: a 4 KB page |
| fillVaddr | input | 32 | Virtual address of the entry being installed |
| fillPaddr | input | 32 | Real address of the page; only the frame bits are stored |
| purgeAll | input | 1 | Invalidate all entries |
| rspValid | output | 1 | Response present (one cycle after a lookup) |
| rspHit | output | 1 | Translation found |
| rspLarge | output | 1 | Hit came from the large array |
| rspPaddr | output | 32 | Translated real address, zero on a miss |

## Verification
The assertions assume that the walker never asks for a lookup or fill while reset is held, and that `lkVaddr` is valid in every cycle `lkValid` is high. The offset checks look one cycle back at that address. They do not assume that fills and lookups are kept apart in time, nor that purges are rare. The stimulus therefore drives lookups, fills and purges freely, in any mix within a cycle. It draws addresses from a narrow pool of tags and set indices, so that hits, same-set evictions, overlapping small and large pages, and refills of resident tags all occur often.

// File: rtl/dpst_pkg.sv
package dpst_pkg;
  localparam int WAYS = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic       purge;
    logic       lkQual;
    logic [1:0] smWe;
    logic [1:0] lgWe;
  } ctrlStrobesT;

  // per-way status from datapath to control
  typedef struct packed {
    logic [1:0] smHit;
    logic [1:0] lgHit;
    logic [1:0] smFillValid;
    logic [1:0] smFillMatch;
    logic [1:0] lgFillValid;
    logic [1:0] lgFillMatch;
  } dpStatusT;
endpackage

// File: rtl/dpst_way_array.sv
module dpst_way_array #(
  parameter int SETS = 256,
  parameter int TAGW = 12,
  parameter int FRW  = 20,
  localparam int IDXW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            purge,
  input  logic [IDXW-1:0] lkIdx,
  input  logic [TAGW-1:0] lkTag,
  input  logic [IDXW-1:0] fillIdx,
  input  logic [TAGW-1:0] fillTag,
  input  logic [FRW-1:0]  fillFrame,
  input  logic [1:0]      we,
  output logic [1:0]      hitVec,
  output logic [FRW-1:0]  hitFrame,
  output logic [1:0]      fillValidVec,
  output logic [1:0]      fillMatchVec
);
  logic [FRW-1:0] wayFrame [2];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0] validMem;
    logic [TAGW-1:0] tagMem   [SETS];
    logic [FRW-1:0]  frameMem [SETS];

    always_ff @(posedge clk) begin
      if (!rstN)       validMem <= '0;
      else if (purge)  validMem <= '0;
      else if (we[w])  validMem[fillIdx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (we[w]) begin
        tagMem[fillIdx]   <= fillTag;
        frameMem[fillIdx] <= fillFrame;
      end
    end

    assign hitVec[w]       = validMem[lkIdx] && (tagMem[lkIdx] == lkTag);
    assign wayFrame[w]     = frameMem[lkIdx];
    assign fillValidVec[w] = validMem[fillIdx];
    assign fillMatchVec[w] = validMem[fillIdx] && (tagMem[fillIdx] == fillTag);
  end

  assign hitFrame = ({FRW{hitVec[0]}} & wayFrame[0]) | ({FRW{hitVec[1]}} & wayFrame[1]);
endmodule

// File: rtl/dpst_datapath.sv
module dpst_datapath
  import dpst_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int SM_OFF  = 12,
  parameter int LG_OFF  = 20,
  parameter int SM_SETS = 256,
  parameter int LG_SETS = 32,
  localparam int SM_IDXW = $clog2(SM_SETS),
  localparam int LG_IDXW = $clog2(LG_SETS),
  localparam int SM_TAGW = VA_W - SM_OFF - SM_IDXW,
  localparam int LG_TAGW = VA_W - LG_OFF - LG_IDXW,
  localparam int SM_FRW  = PA_W - SM_OFF,
  localparam int LG_FRW  = PA_W - LG_OFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobesT      strobes,
  input  logic             lkValid,
  input  logic [VA_W-1:0]  lkVaddr,
  input  logic [VA_W-1:0]  fillVaddr,
  input  logic [PA_W-1:0]  fillPaddr,
  output dpStatusT         status,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspLarge,
  output logic [PA_W-1:0]  rspPaddr
);
  logic [SM_FRW-1:0] smFrame;
  logic [LG_FRW-1:0] lgFrame;
  logic              smAny, lgAny;
  logic [PA_W-1:0]   nextPaddr;

  dpst_way_array #(.SETS(SM_SETS), .TAGW(SM_TAGW), .FRW(SM_FRW)) u_small (
    .clk(clk), .rstN(rstN), .purge(strobes.purge),
    .lkIdx(lkVaddr[SM_OFF +: SM_IDXW]), .lkTag(lkVaddr[VA_W-1 -: SM_TAGW]),
    .fillIdx(fillVaddr[SM_OFF +: SM_IDXW]), .fillTag(fillVaddr[VA_W-1 -: SM_TAGW]),
    .fillFrame(fillPaddr[PA_W-1 -: SM_FRW]), .we(strobes.smWe),
    .hitVec(status.smHit), .hitFrame(smFrame),
    .fillValidVec(status.smFillValid), .fillMatchVec(status.smFillMatch)
  );

  dpst_way_array #(.SETS(LG_SETS), .TAGW(LG_TAGW), .FRW(LG_FRW)) u_large (
    .clk(clk), .rstN(rstN), .purge(strobes.purge),
    .lkIdx(lkVaddr[LG_OFF +: LG_IDXW]), .lkTag(lkVaddr[VA_W-1 -: LG_TAGW]),
    .fillIdx(fillVaddr[LG_OFF +: LG_IDXW]), .fillTag(fillVaddr[VA_W-1 -: LG_TAGW]),
    .fillFrame(fillPaddr[PA_W-1 -: LG_FRW]), .we(strobes.lgWe),
    .hitVec(status.lgHit), .hitFrame(lgFrame),
    .fillValidVec(status.lgFillValid), .fillMatchVec(status.lgFillMatch)
  );

  assign smAny = strobes.lkQual && (|status.smHit);
  assign lgAny = strobes.lkQual && (|status.lgHit);

  always_comb begin
    nextPaddr = '0;
    if (lgAny)      nextPaddr = {lgFrame, lkVaddr[LG_OFF-1:0]};
    else if (smAny) nextPaddr = {smFrame, lkVaddr[SM_OFF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspLarge <= 1'b0;
      rspPaddr <= '0;
    end else begin
      rspValid <= lkValid;
      rspHit   <= smAny || lgAny;
      rspLarge <= lgAny;
      rspPaddr <= nextPaddr;
    end
  end
endmodule

// File: rtl/dpst_control.sv
module dpst_control
  import dpst_pkg::*;
#(
  parameter int SM_SETS = 256,
  parameter int LG_SETS = 32,
  localparam int SM_IDXW = $clog2(SM_SETS),
  localparam int LG_IDXW = $clog2(LG_SETS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic               fillValid,
  input  logic               fillLarge,
  input  logic               purgeAll,
  input  logic [SM_IDXW-1:0] lkSmIdx,
  input  logic [LG_IDXW-1:0] lkLgIdx,
  input  logic [SM_IDXW-1:0] fillSmIdx,
  input  logic [LG_IDXW-1:0] fillLgIdx,
  input  dpStatusT           status,
  output ctrlStrobesT        strobes
);
  // victim pointer per set: value is the way to replace next
  logic [SM_SETS-1:0] smLru;
  logic [LG_SETS-1:0] lgLru;
  logic smWay, lgWay, smFill, lgFill;

  function automatic logic pickWay(input logic [1:0] valid, input logic [1:0] match,
                                   input logic lru);
    if (match[0])      return 1'b0;
    else if (match[1]) return 1'b1;
    else if (!valid[0]) return 1'b0;
    else if (!valid[1]) return 1'b1;
    else               return lru;
  endfunction

  assign smWay  = pickWay(status.smFillValid, status.smFillMatch, smLru[fillSmIdx]);
  assign lgWay  = pickWay(status.lgFillValid, status.lgFillMatch, lgLru[fillLgIdx]);
  assign smFill = fillValid && !fillLarge && !purgeAll;
  assign lgFill = fillValid && fillLarge && !purgeAll;

  always_comb begin
    strobes.purge  = purgeAll;
    strobes.lkQual = lkValid && !purgeAll;
    strobes.smWe   = smFill ? (smWay ? 2'b10 : 2'b01) : 2'b00;
    strobes.lgWe   = lgFill ? (lgWay ? 2'b10 : 2'b01) : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      smLru <= '0;
      lgLru <= '0;
    end else begin
      if (strobes.lkQual && (|status.smHit)) smLru[lkSmIdx] <= status.smHit[0];
      if (strobes.lkQual && (|status.lgHit)) lgLru[lkLgIdx] <= status.lgHit[0];
      if (smFill) smLru[fillSmIdx] <= !smWay;
      if (lgFill) lgLru[fillLgIdx] <= !lgWay;
    end
  end
endmodule

// File: rtl/dpst_tlb.sv
module dpst_tlb
  import dpst_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int SM_OFF  = 12,
  parameter int LG_OFF  = 20,
  parameter int SM_SETS = 256,
  parameter int LG_SETS = 32,
  localparam int SM_IDXW = $clog2(SM_SETS),
  localparam int LG_IDXW = $clog2(LG_SETS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lkValid,
  input  logic [VA_W-1:0] lkVaddr,
  input  logic            fillValid,
  input  logic            fillLarge,
  input  logic [VA_W-1:0] fillVaddr,
  input  logic [PA_W-1:0] fillPaddr,
  input  logic            purgeAll,
  output logic            rspValid,
  output logic            rspHit,
  output logic            rspLarge,
  output logic [PA_W-1:0] rspPaddr
);
  ctrlStrobesT strobes;
  dpStatusT    status;

  dpst_control #(.SM_SETS(SM_SETS), .LG_SETS(LG_SETS)) u_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .fillValid(fillValid),
    .fillLarge(fillLarge), .purgeAll(purgeAll),
    .lkSmIdx(lkVaddr[SM_OFF +: SM_IDXW]), .lkLgIdx(lkVaddr[LG_OFF +: LG_IDXW]),
    .fillSmIdx(fillVaddr[SM_OFF +: SM_IDXW]), .fillLgIdx(fillVaddr[LG_OFF +: LG_IDXW]),
    .status(status), .strobes(strobes)
  );

  dpst_datapath #(.VA_W(VA_W), .PA_W(PA_W), .SM_OFF(SM_OFF), .LG_OFF(LG_OFF),
                  .SM_SETS(SM_SETS), .LG_SETS(LG_SETS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lkValid(lkValid), .lkVaddr(lkVaddr),
    .fillVaddr(fillVaddr), .fillPaddr(fillPaddr), .status(status),
    .rspValid(rspValid), .rspHit(rspHit), .rspLarge(rspLarge), .rspPaddr(rspPaddr)
  );
endmodule

// File: rtl/dpst_tlb_checker.sv
module dpst_tlb_checker #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int SM_OFF = 12,
  parameter int LG_OFF = 20
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic [VA_W-1:0] lkVaddr,
  input logic            purgeAll,
  input logic            rspValid,
  input logic            rspHit,
  input logic            rspLarge,
  input logic [PA_W-1:0] rspPaddr
);
  a_r2_rsp_after_lookup: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);
  a_r2_no_rsp_without_lookup: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);
  a_r1_hit_needs_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rspHit && !rspLarge);
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspPaddr == '0) && !rspLarge);
  a_r10_purge_lookup_miss: assert property (@(posedge clk) disable iff (!rstN)
    (purgeAll && lkValid) |=> !rspHit);
  a_r3_small_offset: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit && !rspLarge) |-> rspPaddr[SM_OFF-1:0] == $past(lkVaddr[SM_OFF-1:0]));
  a_r4_large_offset: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit && rspLarge) |-> rspPaddr[LG_OFF-1:0] == $past(lkVaddr[LG_OFF-1:0]));
endmodule

bind dpst_tlb dpst_tlb_checker #(.VA_W(VA_W), .PA_W(PA_W), .SM_OFF(SM_OFF), .LG_OFF(LG_OFF))
  u_chk (.clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVaddr(lkVaddr), .purgeAll(purgeAll),
         .rspValid(rspValid), .rspHit(rspHit), .rspLarge(rspLarge), .rspPaddr(rspPaddr));

// File: tb/dpst_tlb_bench.sv
module dpst_tlb_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0, fillValid = 1'b0, fillLarge = 1'b0, purgeAll = 1'b0;
  logic [31:0] lkVaddr = '0, fillVaddr = '0, fillPaddr = '0;
  logic        rspValid, rspHit, rspLarge;
  logic [31:0] rspPaddr;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dpst_tlb u_dpst_tlb (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVaddr(lkVaddr),
    .fillValid(fillValid), .fillLarge(fillLarge), .fillVaddr(fillVaddr),
    .fillPaddr(fillPaddr), .purgeAll(purgeAll), .rspValid(rspValid),
    .rspHit(rspHit), .rspLarge(rspLarge), .rspPaddr(rspPaddr)
  );

  // reference model state
  bit        mSmV [256][2];
  bit [11:0] mSmT [256][2];
  bit [19:0] mSmF [256][2];
  bit        mSmL [256];
  bit        mLgV [32][2];
  bit [6:0]  mLgT [32][2];
  bit [11:0] mLgF [32][2];
  bit        mLgL [32];

  bit        expPend = 0, expHit = 0, expLg = 0;
  bit [31:0] expPa = '0;
  string     expTag = "R2";

  function automatic bit chooseWay(bit v0, bit v1, bit m0, bit m1, bit lru);
    if (m0) return 0;
    if (m1) return 1;
    if (!v0) return 0;
    if (!v1) return 1;
    return lru;
  endfunction

  task automatic checkPrev();
    checks++;
    if (!expPend) begin
      if (rspValid !== 1'b0 || rspHit !== 1'b0) begin
        failures++;
        $display("FAIL R2 idle: rspValid=%b rspHit=%b expected 0 0", rspValid, rspHit);
      end
    end else if (rspValid !== 1'b1 || rspHit !== expHit || rspLarge !== expLg || rspPaddr !== expPa) begin
      failures++;
      $display("FAIL %s: valid=%b hit=%b large=%b pa=%h expected 1 %b %b %h",
               expTag, rspValid, rspHit, rspLarge, rspPaddr, expHit, expLg, expPa);
    end
  endtask

  task automatic step(bit lk, bit [31:0] va, bit fl, bit lg, bit [31:0] fva,
                      bit [31:0] fpa, bit pg, string tag);
    bit [7:0] si; bit [11:0] st; bit [4:0] li; bit [6:0] lt;
    bit smh, lgh, smw, lgw, fw;
    bit [7:0] fsi; bit [4:0] fli;
    @(negedge clk);
    checkPrev();
    si = va[19:12]; st = va[31:20]; li = va[24:20]; lt = va[31:25];
    smh = 0; lgh = 0; smw = 0; lgw = 0;
    for (int w = 0; w < 2; w++) begin
      if (mSmV[si][w] && mSmT[si][w] == st) begin smh = 1; smw = w[0]; end
      if (mLgV[li][w] && mLgT[li][w] == lt) begin lgh = 1; lgw = w[0]; end
    end
    expPend = lk; expHit = 0; expLg = 0; expPa = '0;
    if (lk && !pg) begin
      if (lgh) begin expHit = 1; expLg = 1; expPa = {mLgF[li][lgw], va[19:0]}; end
      else if (smh) begin expHit = 1; expPa = {mSmF[si][smw], va[11:0]}; end
    end
    if (tag != "") expTag = tag;
    else if (lk && pg) expTag = "R10";
    else if (expLg) expTag = "R4";
    else if (expHit) expTag = "R3";
    else expTag = "R6";
    // victim choice from pre-cycle state
    fsi = fva[19:12]; fli = fva[24:20];
    if (lg) fw = chooseWay(mLgV[fli][0], mLgV[fli][1],
                           mLgV[fli][0] && mLgT[fli][0] == fva[31:25],
                           mLgV[fli][1] && mLgT[fli][1] == fva[31:25], mLgL[fli]);
    else    fw = chooseWay(mSmV[fsi][0], mSmV[fsi][1],
                           mSmV[fsi][0] && mSmT[fsi][0] == fva[31:20],
                           mSmV[fsi][1] && mSmT[fsi][1] == fva[31:20], mSmL[fsi]);
    if (lk && !pg) begin
      if (smh) mSmL[si] = (smw == 0);
      if (lgh) mLgL[li] = (lgw == 0);
    end
    if (pg) begin
      for (int s = 0; s < 256; s++) begin mSmV[s][0] = 0; mSmV[s][1] = 0; end
      for (int s = 0; s < 32; s++) begin mLgV[s][0] = 0; mLgV[s][1] = 0; end
    end else if (fl) begin
      if (lg) begin
        mLgV[fli][fw] = 1; mLgT[fli][fw] = fva[31:25]; mLgF[fli][fw] = fpa[31:20];
        mLgL[fli] = (fw == 0);
      end else begin
        mSmV[fsi][fw] = 1; mSmT[fsi][fw] = fva[31:20]; mSmF[fsi][fw] = fpa[31:12];
        mSmL[fsi] = (fw == 0);
      end
    end
    lkValid = lk; lkVaddr = va; fillValid = fl; fillLarge = lg;
    fillVaddr = fva; fillPaddr = fpa; purgeAll = pg;
  endtask

  task automatic look(bit [31:0] va, string tag);
    step(1, va, 0, 0, 32'h0, 32'h0, 0, tag);
  endtask

  task automatic fill(bit lg, bit [31:0] va, bit [31:0] pa, string tag);
    step(0, 32'h0, 1, lg, va, pa, 0, tag);
  endtask

  task automatic idle();
    step(0, 32'h0, 0, 0, 32'h0, 32'h0, 0, "");
  endtask

  initial begin
    void'($urandom(32'h5eed_7a1b));
    for (int s = 0; s < 256; s++) begin mSmV[s][0] = 0; mSmV[s][1] = 0; mSmL[s] = 0; end
    for (int s = 0; s < 32; s++) begin mLgV[s][0] = 0; mLgV[s][1] = 0; mLgL[s] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0) begin
      failures++;
      $display("FAIL R1: rspValid=%b rspHit=%b expected 0 0", rspValid, rspHit);
    end
    look(32'h0000_5123, "R1");
    look(32'h0300_0000, "R1");
    // R7 and R8: same small set
    fill(0, 32'h0000_5000, 32'hAAAA_A000, "");
    fill(0, 32'h0010_5000, 32'hBBBB_B000, "");
    look(32'h0000_5abc, "R7");
    look(32'h0010_5def, "R7");
    look(32'h0000_5001, "R8");
    fill(0, 32'h0020_5000, 32'hCCCC_C000, "");
    look(32'h0010_5000, "R8");
    look(32'h0000_5002, "R8");
    look(32'h0020_5fff, "R8");
    // R9: refill of resident tag
    fill(0, 32'h0000_5000, 32'h1111_1000, "");
    look(32'h0000_5010, "R9");
    look(32'h0020_5010, "R9");
    // R4, R5: large page overlapping a small one
    fill(0, 32'h0030_1000, 32'h1234_5000, "");
    look(32'h0030_1abc, "R3");
    fill(1, 32'h0030_0000, 32'hABC0_0000, "");
    look(32'h0030_1abc, "R5");
    look(32'h003f_f345, "R4");
    // R11: lookup in the fill cycle sees old contents
    step(1, 32'h0770_2222, 1, 0, 32'h0770_2000, 32'h5555_5000, 0, "R11");
    look(32'h0770_2222, "R11");
    // R10: purge with lookup, purge with fill
    step(1, 32'h0030_1abc, 0, 0, 32'h0, 32'h0, 1, "R10");
    look(32'h0030_1abc, "R10");
    step(0, 32'h0, 1, 0, 32'h0040_7000, 32'h7777_7000, 1, "");
    look(32'h0040_7000, "R10");
    idle();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit [31:0] va, fva, fpa;
      va  = {6'h0, 1'($urandom_range(0, 1)), 5'($urandom_range(0, 2)),
             8'($urandom_range(0, 3)), 12'($urandom)};
      fva = {6'h0, 1'($urandom_range(0, 1)), 5'($urandom_range(0, 2)),
             8'($urandom_range(0, 3)), 12'($urandom)};
      fpa = $urandom;
      step($urandom_range(0, 9) < 7, va, $urandom_range(0, 9) < 4,
           $urandom_range(0, 9) < 3, fva, fpa, $urandom_range(0, 99) == 0, "");
    end
    idle();
    idle();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule